// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block is the CPU-side half of a cartridge memory mapper for a 128 KB program ROM seen through a 32 KB CPU window. It decodes the CPU address into one switchable 8 KB window and three fixed 8 KB windows. It holds two writable registers, the switchable bank number and a nametable mirroring bit. It drives the upper program ROM address lines, a ROM chip select, the video-RAM A10 select and an optional work-RAM enable.

Register writes are decoded from the top address nibble alone and take effect on the clock edge where the write strobe is seen with R/W low. The block never reads the ROM data bus, so a write is not disturbed by what the ROM drives. The two pattern-bank registers that share the same write space are decoded by a separate block, so writes to their nibbles are ignored here.

Top module: `prg_mapper`

## Requirements
- R1: After a synchronous active-low reset the switchable bank is 0 and mirroring is vertical (`vram_a10` follows `ppu_a10`).
- R2: For CPU addresses $8000-$9FFF (`cpu_addr[14:13]` = 00), `prg_bank` (ROM A16:A13) equals the switchable bank register.
- R3: For `cpu_addr[14:13]` = 01, 10 and 11 (CPU $A000, $C000, $E000 windows), `prg_bank` is 13, 14 and 15 respectively, whatever the register holds.
- R4: A write (`cpu_wr_stb`=1, `cpu_rw`=0) with `cpu_addr[15:12]` = 4'hA loads `cpu_data[3:0]` into the bank register, visible from the cycle after the edge; `cpu_data[7:4]` has no effect.
- R5: A write with `cpu_addr[15:12]` = 4'hF loads `cpu_data[0]` into the mirroring bit (0 vertical, 1 horizontal); other data bits have no effect.
- R6: Writes to any other top nibble ($0-$9, $B-$E) change neither the bank register nor the mirroring bit.
- R7: A cycle with `cpu_rw`=1 or `cpu_wr_stb`=0 changes no register.
- R8: `vram_a10` equals `ppu_a10` when the mirroring bit is 0 and `ppu_a11` when it is 1.
- R9: `wram_en` is 1 exactly for CPU $6000-$7FFF (`cpu_addr[15:13]` = 011).
- R10: `rom_cs` is 1 exactly when `cpu_addr[15]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wr_stb | input | 1 | Bus cycle strobe qualifying a write |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_bank | output | 4 | Program ROM address bits A16:A13 |
| rom_cs | output | 1 | Program ROM select |
| wram_en | output | 1 | Work-RAM enable |
| vram_a10 | output | 1 | Nametable RAM A10 |

## Verification
The assertions assume the CPU inputs are settled at each rising edge and that a write strobe lasts one clock, so a single edge carries one register update. The bench drives every input on the falling edge, holds each write for exactly one rising edge and returns R/W high afterwards, and checks combinational outputs a short time after the address changes. Address sweeps step through all 256 pages of the CPU space with every bank value and both mirroring settings.

// File: rtl/prg_mapper_pkg.sv
// Shared constants and types for the program bank mapper.
// Assumes a 16-bit CPU address whose top nibble selects the register.
package prg_mapper_pkg;

    // Top-nibble codes that this block owns in the write space.
    localparam logic [3:0] NIB_BANK   = 4'hA;
    localparam logic [3:0] NIB_MIRROR = 4'hF;

    // Work-RAM page code in the top three address bits.
    localparam logic [2:0] WRAM_PAGE  = 3'b011;

    // Which 8 KB slot of the upper 32 KB is being addressed.
    typedef enum logic [1:0] {
        SLOT_SWITCH = 2'd0,
        SLOT_FIX_A  = 2'd1,
        SLOT_FIX_B  = 2'd2,
        SLOT_FIX_C  = 2'd3
    } slot_e;

endpackage

// File: rtl/prg_reg_file.sv
// Register file of the mapper: decodes CPU writes by top address nibble
// and holds the switchable bank number and the mirroring bit.
// Assumes inputs are stable at the rising edge; reads never change state.
module prg_reg_file
    import prg_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_wr_stb,
    output logic [BANK_W-1:0] bank_q,
    output logic              mirror_q
);

    logic       wr_fire;
    logic [3:0] nibble;
    logic       hit_bank;
    logic       hit_mirror;

    // Qualify a write cycle and pick out the register selector.
    always_comb begin
        wr_fire    = cpu_wr_stb && !cpu_rw;
        nibble     = cpu_addr[ADDR_W-1 -: 4];
        hit_bank   = wr_fire && (nibble == NIB_BANK);
        hit_mirror = wr_fire && (nibble == NIB_MIRROR);
    end

    // Bank register: loaded from the low data bits on a bank write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (hit_bank) begin
            bank_q <= cpu_data[BANK_W-1:0];
        end
    end

    // Mirroring bit: loaded from data bit 0 on a mirroring write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_q <= 1'b0;
        end else if (hit_mirror) begin
            mirror_q <= cpu_data[0];
        end
    end

endmodule

// File: rtl/prg_window_map.sv
// Address map of the upper 32 KB: one switchable slot and three slots
// fixed to the last three banks of the ROM. Pure combinational.
// Assumes the ROM holds 2**BANK_W banks of 8 KB.
module prg_window_map
    import prg_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 4
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0] prg_bank,
    output logic              rom_cs
);

    localparam int               NUM_BANKS   = 1 << BANK_W;
    localparam logic [BANK_W-1:0] FIRST_FIXED = BANK_W'(NUM_BANKS - 3);

    slot_e slot;

    // Select the bank number for the addressed 8 KB slot.
    always_comb begin
        slot = slot_e'(cpu_addr[ADDR_W-2 -: 2]);
        unique case (slot)
            SLOT_SWITCH: prg_bank = bank_q;
            SLOT_FIX_A:  prg_bank = FIRST_FIXED;
            SLOT_FIX_B:  prg_bank = FIRST_FIXED + BANK_W'(1);
            SLOT_FIX_C:  prg_bank = FIRST_FIXED + BANK_W'(2);
            default:     prg_bank = bank_q;
        endcase
    end

    // ROM occupies the upper half of the CPU space.
    always_comb rom_cs = cpu_addr[ADDR_W-1];

endmodule

// File: rtl/wram_decode.sv
// Work-RAM enable for the 8 KB page below the ROM, present only when
// HAS_WRAM is set; otherwise tied inactive.
module wram_decode
    import prg_mapper_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter bit HAS_WRAM = 1'b1
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              wram_en
);

    generate
        if (HAS_WRAM) begin : g_wram
            // Page compare on the top three address bits.
            always_comb wram_en = (cpu_addr[ADDR_W-1 -: 3] == WRAM_PAGE);
        end else begin : g_no_wram
            // No work RAM fitted.
            always_comb wram_en = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/nt_mirror_mux.sv
// Nametable A10 select: vertical mirroring passes PPU A10,
// horizontal mirroring passes PPU A11.
module nt_mirror_mux (
    input  logic mirror_q,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic vram_a10
);

    // Choose the PPU address bit that splits the two nametables.
    always_comb vram_a10 = mirror_q ? ppu_a11 : ppu_a10;

endmodule

// File: rtl/prg_mapper.sv
// Top of the CPU-side program bank mapper. Ties together the register
// file, the window map, the work-RAM decode and the mirroring mux.
// Assumes one write per strobe and no dependence on ROM read data.
module prg_mapper #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter bit HAS_WRAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_wr_stb,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic [BANK_W-1:0] prg_bank,
    output logic              rom_cs,
    output logic              wram_en,
    output logic              vram_a10
);

    logic [BANK_W-1:0] bank_q;
    logic              mirror_q;

    prg_reg_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb),
        .bank_q(bank_q), .mirror_q(mirror_q)
    );

    prg_window_map #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_map (
        .cpu_addr(cpu_addr), .bank_q(bank_q),
        .prg_bank(prg_bank), .rom_cs(rom_cs)
    );

    wram_decode #(
        .ADDR_W(ADDR_W), .HAS_WRAM(HAS_WRAM)
    ) u_wram (
        .cpu_addr(cpu_addr), .wram_en(wram_en)
    );

    nt_mirror_mux u_mirror (
        .mirror_q(mirror_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .vram_a10(vram_a10)
    );

endmodule

// File: rtl/prg_mapper_checker.sv
// Property checker for prg_mapper, attached with bind below.
module prg_mapper_checker #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4,
    parameter bit HAS_WRAM = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_rw,
    input logic              cpu_wr_stb,
    input logic              ppu_a10,
    input logic              ppu_a11,
    input logic [BANK_W-1:0] prg_bank,
    input logic              rom_cs,
    input logic              wram_en,
    input logic              vram_a10,
    input logic [BANK_W-1:0] bank_q,
    input logic              mirror_q
);

    logic [3:0] nib;
    logic       wr;
    assign nib = cpu_addr[ADDR_W-1 -: 4];
    assign wr  = cpu_wr_stb && !cpu_rw;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (bank_q == '0 && !mirror_q));

    assert_switch_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-2 -: 2] == 2'd0) |-> (prg_bank == bank_q));

    assert_last_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-2 -: 2] == 2'd3) |-> (prg_bank == {BANK_W{1'b1}}));

    assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && nib == 4'hA) |=> (bank_q == $past(cpu_data[BANK_W-1:0])));

    assert_mirror_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && nib == 4'hF) |=> (mirror_q == $past(cpu_data[0])));

    assert_foreign_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && nib != 4'hA && nib != 4'hF) |=> ($stable(bank_q) && $stable(mirror_q)));

    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(bank_q) && $stable(mirror_q)));

    assert_nt_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vram_a10 == (mirror_q ? ppu_a11 : ppu_a10));

    assert_wram_rom_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wram_en && rom_cs));

    assert_rom_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs == cpu_addr[ADDR_W-1]);

endmodule

bind prg_mapper prg_mapper_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .HAS_WRAM(HAS_WRAM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb), .ppu_a10(ppu_a10),
    .ppu_a11(ppu_a11), .prg_bank(prg_bank), .rom_cs(rom_cs),
    .wram_en(wram_en), .vram_a10(vram_a10), .bank_q(bank_q),
    .mirror_q(mirror_q)
);

// File: tb/prg_mapper_tb.sv
// Self-checking bench: sweeps the CPU address space against every bank
// value, writes to every nibble, and both mirroring settings.
module prg_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_wr_stb = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic [3:0]  prg_bank;
    logic        rom_cs;
    logic        wram_en;
    logic        vram_a10;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int exp_bank = 0;
    int exp_mir  = 0;

    always #4 clk = ~clk;

    prg_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_wr_stb(cpu_wr_stb), .ppu_a10(ppu_a10),
        .ppu_a11(ppu_a11), .prg_bank(prg_bank), .rom_cs(rom_cs),
        .wram_en(wram_en), .vram_a10(vram_a10)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bus cycle driven at the falling edge, held over one rising edge.
    task automatic bus(input logic [15:0] a, input logic [7:0] d,
                       input logic rw, input logic stb);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_wr_stb = stb;
        @(negedge clk);
        cpu_rw = 1'b1; cpu_wr_stb = 1'b0;
    endtask

    // Bank register observed through the switchable window.
    task automatic chk_bank(input string req);
        cpu_addr = 16'h8000; #1;
        chk(req, prg_bank, exp_bank);
    endtask

    // Mirroring observed with A10 and A11 set apart.
    task automatic chk_mir(input string req);
        ppu_a10 = 1'b0; ppu_a11 = 1'b1; #1;
        chk(req, vram_a10, exp_mir);
        ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
        chk(req, vram_a10, 1 - exp_mir);
    endtask

    // Walk every 256-byte page and compare the decoded outputs.
    task automatic sweep();
        for (int p = 0; p < 256; p++) begin
            int slot;
            cpu_addr = 16'(p << 8) | 16'h0055; #1;
            slot = (p >> 5) & 3;
            if (slot == 0) chk("R2 switch window", prg_bank, exp_bank);
            else           chk("R3 fixed window", prg_bank, 12 + slot);
            chk("R10 rom_cs", rom_cs, (p >= 128) ? 1 : 0);
            chk("R9 wram_en", wram_en, (p >= 96 && p < 128) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: dirty the registers, then reset and check the cleared state.
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus(16'hA000, 8'h07, 1'b0, 1'b1);
        bus(16'hF000, 8'h01, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_bank = 0; exp_mir = 0;
        chk_bank("R1 reset bank");
        chk_mir("R1 reset mirroring");
        rst_n = 1'b1;

        // R4, R2, R3, R9, R10: every bank value with garbage in the upper bits.
        for (int b = 0; b < 16; b++) begin
            bus(16'hA000 | 16'(b * 16'h0111), 8'(((15 - b) << 4) | b), 1'b0, 1'b1);
            exp_bank = b;
            chk_bank("R4 bank load");
            sweep();
        end

        // R5: mirroring bit from data bit 0, other bits set or clear.
        bus(16'hF123, 8'hFF, 1'b0, 1'b1); exp_mir = 1; chk_mir("R5 mirror set");
        bus(16'hFFFF, 8'hFE, 1'b0, 1'b1); exp_mir = 0; chk_mir("R5 mirror clear");
        bus(16'hF800, 8'h01, 1'b0, 1'b1); exp_mir = 1; chk_mir("R8 horizontal");
        for (int b = 0; b < 16; b++) begin
            bus(16'hA000, 8'(b), 1'b0, 1'b1);
            exp_bank = b;
            sweep();
        end
        bus(16'hF000, 8'h00, 1'b0, 1'b1); exp_mir = 0; chk_mir("R8 vertical");

        // R6: writes to every foreign nibble leave both registers alone.
        bus(16'hA000, 8'h05, 1'b0, 1'b1); exp_bank = 5;
        for (int n = 0; n < 16; n++) begin
            if (n != 10 && n != 15) begin
                bus(16'(n << 12) | 16'h0ABC, 8'hFA, 1'b0, 1'b1);
                chk_bank("R6 foreign nibble bank");
                chk_mir("R6 foreign nibble mirror");
            end
        end

        // R7: reads with strobe, and writes without strobe, change nothing.
        bus(16'hA000, 8'h0C, 1'b1, 1'b1);
        chk_bank("R7 read cycle bank");
        bus(16'hA000, 8'h0C, 1'b0, 1'b0);
        chk_bank("R7 no strobe bank");
        bus(16'hF000, 8'h01, 1'b1, 1'b1);
        chk_mir("R7 read cycle mirror");
        bus(16'hF000, 8'h01, 1'b0, 1'b0);
        chk_mir("R7 no strobe mirror");

        // R4: bank visible from the cycle right after the edge.
        bus(16'hAFFF, 8'h09, 1'b0, 1'b1); exp_bank = 9;
        chk_bank("R4 next cycle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule